// File: doc/BRIEF.md
# Byte-Wide Serial Master with Collision Lockout

This block drives one byte at a time out of a four-wire serial master port and captures one byte back. A one-cycle write strobe with a byte starts a transfer. The serial clock comes from one of three fixed divisions of the system clock, or from an external timer's period-match tick at half that tick's rate. Three settings choose the waveform: the idle level of the serial clock, whether output data changes on the edge that returns to idle or on the edge that leaves idle, and whether input sampling happens in the middle or at the end of each data window.

A write that arrives while a byte is still shifting is refused. It raises a sticky collision flag and leaves the clock and the data untouched. The received byte is offered on a valid/ready pair. `rx_valid` stays high, and `rx_data` holds still, until the consumer asserts `rx_ready`; a new byte that completes before the old one is taken overwrites it. The write side is a plain strobe and not a handshake, so that a refused write stays visible as a collision instead of stalling. Dropping `en` puts the block back to idle on the next clock edge.

Top module: `spi_wcol_master`

## Requirements
- R1: A write (`wr`=1) while `en`=1 and `busy`=0 is accepted. `busy` is high from the next cycle. Exactly 8 serial clock pulses follow, and `sdo` presents the byte most-significant bit first.
- R2: While `busy`=0, whether the block is enabled or not, `sck` equals `cpol`.
- R3: A transfer is 17 half-periods, numbered 0..16, and `sck` is away from `cpol` in the odd ones. Bit j (j=0 is the MSB) is driven from half-period 2j+d, where d=0 when `cedge`=1 and d=1 when `cedge`=0. It is captured from `sdi` at the end of half-period 2j+d+`smp_late`. All 8 bits, including the last, land in `rx_data` in every combination.
- R4: `clk_sel` 4'b0000, 4'b0001 and 4'b0010 give half-periods of 2, 8 and 32 system cycles (sck = clk/4, /16, /64). Any value other than these three and 4'b0011 behaves as 4'b0010. Each half-period starts counting from the first busy cycle.
- R5: With `clk_sel`=4'b0011, the first `tmr_match` pulse after a write only opens half-period 0. Each later pulse ends one half-period, so every high or low phase of `sck` lasts exactly one timer period, the first one included.
- R6: A write while `busy`=1 sets `wcol` on the next cycle. Its data is discarded, and `sck`, `sdo` and the length of the transfer are unaffected.
- R7: `wcol` stays set until a cycle with `wcol_clr`=1 and no new collision, or until `en` is low. A collision in the same cycle as `wcol_clr` leaves it set.
- R8: `rx_valid` rises one cycle after `busy` falls and stays high, with `rx_data` stable, until a cycle with `rx_ready`=1.
- R9: With `en`=0 the block is idle on the following cycle: `busy`, `wcol` and `rx_valid` are 0, and writes are ignored. Enabling in any `cpol`/`cedge` combination produces no pulse on `sck`.
- R10: `busy` falls on the cycle after the tick that ends half-period 16, and `rx_data` holds the received byte from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en | input | 1 | Block enable; low forces idle |
| cpol | input | 1 | Idle level of sck |
| cedge | input | 1 | 1: data changes when sck returns to idle; 0: when sck leaves idle |
| smp_late | input | 1 | 1: sample at end of data window; 0: in its middle |
| clk_sel | input | 4 | Serial clock source select |
| tmr_match | input | 1 | One-cycle external timer period-match pulse |
| wr | input | 1 | Data buffer write strobe |
| wdata | input | 8 | Byte to transmit |
| wcol_clr | input | 1 | Clears the collision flag |
| rx_ready | input | 1 | Consumer takes the received byte |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| wcol | output | 1 | Sticky write-collision flag |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |

## Verification
Every result has a fixed due cycle. `busy` rises one cycle after the accepted write. `sck` and `sdo` reflect the half-period counter in the same cycle it advances. `busy` falls and `rx_data` updates one cycle after the final tick, and `rx_valid` follows a cycle later. `wcol` is due one cycle after the colliding write, and idle one cycle after `en` drops. The bench drives inputs and samples outputs on the falling clock edge. It carries its own half-period and divider model that advances on the same ticks it schedules, so each comparison falls in the cycle where the design's registers have just changed. `sdi` carries the wanted bit only on the single tick where R3 says it is captured and random bits on every other cycle, so a capture that is early or late by one tick corrupts `rx_data`.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Clock-source encodings of the 4-bit select field
  localparam logic [3:0] SEL_DIV_A = 4'b0000;
  localparam logic [3:0] SEL_DIV_B = 4'b0001;
  localparam logic [3:0] SEL_DIV_C = 4'b0010;
  localparam logic [3:0] SEL_TIMER = 4'b0011;

  // Waveform settings frozen at the moment a write is accepted
  typedef struct packed {
    logic       cedge;
    logic       smp_late;
    logic [3:0] sel;
  } spim_cfg_t;

endpackage

// File: rtl/spim_tick_gen.sv
module spim_tick_gen
  import spim_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16,
  parameter int DIV_C = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] sel,
  input  logic       tmr_match,
  output logic       tick
);

  localparam int CNT_W = $clog2(DIV_C / 2 + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             use_tmr;

  always_comb begin
    case (sel)
      SEL_DIV_A: half_m1 = CNT_W'(DIV_A / 2 - 1);
      SEL_DIV_B: half_m1 = CNT_W'(DIV_B / 2 - 1);
      default:   half_m1 = CNT_W'(DIV_C / 2 - 1);
    endcase
    use_tmr = (sel == SEL_TIMER);
  end

  // Counter sits at zero until a transfer runs, so half-period 0 is full length
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || use_tmr)   cnt <= '0;
    else if (cnt == half_m1)    cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = run && (use_tmr ? tmr_match : (cnt == half_m1));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic              wait_first,
  input  logic [DATA_W-1:0] load_data,
  input  logic              cedge_q,
  input  logic              smp_q,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              sck_phase,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int HP_N     = 2 * DATA_W + 1;
  localparam int HP_W     = $clog2(HP_N);
  localparam int LAST_REL = 2 * DATA_W - 2;

  logic [HP_W-1:0]   hp;
  logic              waiting;
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] rx_next;
  logic              off_b;
  logic              step;
  logic              cap_now;
  logic              shift_now;
  logic              last_hp;
  int                rel_cap;
  int                rel_out;

  always_comb begin
    off_b     = ~cedge_q;
    step      = busy && tick && !waiting;
    rel_cap   = int'(hp) - int'(off_b) - int'(smp_q);
    rel_out   = int'(hp) + 1 - int'(off_b);
    cap_now   = step && (rel_cap >= 0) && (rel_cap <= LAST_REL) && !rel_cap[0];
    shift_now = step && (rel_out >= 2) && (rel_out <= LAST_REL) && !rel_out[0];
    rx_next   = cap_now ? {rx_sr[DATA_W-2:0], sdi} : rx_sr;
    last_hp   = (hp == HP_W'(HP_N - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      waiting <= 1'b0;
      hp      <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy    <= 1'b0;
        waiting <= 1'b0;
        hp      <= '0;
        tx_sr   <= '0;
        rx_sr   <= '0;
        rx_byte <= '0;
      end else if (start) begin
        busy    <= 1'b1;
        waiting <= wait_first;
        hp      <= '0;
        tx_sr   <= load_data;
        rx_sr   <= '0;
      end else if (busy && tick) begin
        if (waiting) begin
          waiting <= 1'b0;
        end else begin
          rx_sr <= rx_next;
          if (shift_now) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
          if (last_hp) begin
            busy    <= 1'b0;
            hp      <= '0;
            done    <= 1'b1;
            rx_byte <= rx_next;
          end else begin
            hp <= hp + 1'b1;
          end
        end
      end
    end
  end

  assign sck_phase = busy & hp[0];
  assign sdo       = tx_sr[DATA_W-1];

endmodule

// File: rtl/spim_flags.sv
module spim_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic collide,
  input  logic wcol_clr,
  input  logic done,
  input  logic rx_ready,
  output logic wcol,
  output logic rx_valid
);

  // A collision in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n)        wcol <= 1'b0;
    else if (!en)      wcol <= 1'b0;
    else if (collide)  wcol <= 1'b1;
    else if (wcol_clr) wcol <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        rx_valid <= 1'b0;
    else if (!en)      rx_valid <= 1'b0;
    else if (done)     rx_valid <= 1'b1;
    else if (rx_ready) rx_valid <= 1'b0;
  end

endmodule

// File: rtl/spi_wcol_master.sv
module spi_wcol_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cpol,
  input  logic              cedge,
  input  logic              smp_late,
  input  logic [3:0]        clk_sel,
  input  logic              tmr_match,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wcol_clr,
  input  logic              rx_ready,
  input  logic              sdi,
  output logic              busy,
  output logic              wcol,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              sdo
);

  spim_cfg_t cfg_q;
  logic      accept;
  logic      collide;
  logic      tick;
  logic      sck_phase;
  logic      done;

  assign accept  = en & wr & ~busy;
  assign collide = en & wr & busy;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= '{cedge: cedge, smp_late: smp_late, sel: clk_sel};
  end

  spim_tick_gen #(
    .DIV_A(DIV_A),
    .DIV_B(DIV_B),
    .DIV_C(DIV_C)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .sel      (cfg_q.sel),
    .tmr_match(tmr_match),
    .tick     (tick)
  );

  spim_shifter #(
    .DATA_W(DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start     (accept),
    .wait_first(clk_sel == SEL_TIMER),
    .load_data (wdata),
    .cedge_q   (cfg_q.cedge),
    .smp_q     (cfg_q.smp_late),
    .tick      (tick),
    .sdi       (sdi),
    .busy      (busy),
    .sck_phase (sck_phase),
    .sdo       (sdo),
    .done      (done),
    .rx_byte   (rx_data)
  );

  spim_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .collide (collide),
    .wcol_clr(wcol_clr),
    .done    (done),
    .rx_ready(rx_ready),
    .wcol    (wcol),
    .rx_valid(rx_valid)
  );

  assign sck = cpol ^ sck_phase;

endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              cpol,
  input logic              wr,
  input logic              wcol_clr,
  input logic              rx_ready,
  input logic              busy,
  input logic              wcol,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              sck
);

  logic sck_q;
  int   lead_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)                         lead_cnt <= 0;
    else if (!busy)                            lead_cnt <= 0;
    else if (sck != cpol && sck_q == cpol)     lead_cnt <= lead_cnt + 1;
  end

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  p_pulse_count_r1: assert property (@(posedge clk) disable iff (!rst_n || !en)
    ($fell(busy) && $past(en)) |-> lead_cnt == DATA_W);

  p_collision_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr && busy) |=> wcol);

  p_wcol_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wcol && !wcol_clr) |=> wcol);

  p_wcol_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wcol) |-> $past(en && wr && busy));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_valid && !rx_ready && !busy) |=> (rx_valid && $stable(rx_data)));

  p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !wcol && !rx_valid));

  p_enable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (!busy && sck == cpol));

endmodule

bind spi_wcol_master spim_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .cpol    (cpol),
  .wr      (wr),
  .wcol_clr(wcol_clr),
  .rx_ready(rx_ready),
  .busy    (busy),
  .wcol    (wcol),
  .rx_valid(rx_valid),
  .rx_data (rx_data),
  .sck     (sck)
);

// File: tb/spi_wcol_master_bench.sv
`timescale 1ns/100ps
module spi_wcol_master_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       cpol = 1'b0;
  logic       cedge = 1'b0;
  logic       smp_late = 1'b0;
  logic [3:0] clk_sel = 4'b0000;
  logic       tmr_match = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wcol_clr = 1'b0;
  logic       rx_ready = 1'b0;
  logic       sdi = 1'b0;
  logic       busy, wcol, rx_valid, sck, sdo;
  logic [7:0] rx_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  spi_wcol_master u_spi_wcol_master (
    .clk(clk), .rst_n(rst_n), .en(en), .cpol(cpol), .cedge(cedge),
    .smp_late(smp_late), .clk_sel(clk_sel), .tmr_match(tmr_match),
    .wr(wr), .wdata(wdata), .wcol_clr(wcol_clr), .rx_ready(rx_ready),
    .sdi(sdi), .busy(busy), .wcol(wcol), .rx_valid(rx_valid),
    .rx_data(rx_data), .sck(sck), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int half_of(input logic [3:0] sel);
    case (sel)
      4'b0000: return 2;
      4'b0001: return 8;
      default: return 32;
    endcase
  endfunction

  // One transfer against the bench's own half-period model
  task automatic run_xfer(input bit pol, input bit ce, input bit sm, input logic [3:0] sel,
                          input logic [7:0] txb, input logic [7:0] rxp,
                          input int tper, input int tphase, input int coll_k, input bit clr_too);
    int hp, cnt, k, tc, hh, off, rc, jo, e_sck, e_sdo, e_busy, leads;
    bit is_t, waiting, fin, tk, tm;
    logic prev_sck;
    string ck_req;
    hh = half_of(sel);
    is_t = (sel == 4'b0011);
    off = ce ? 0 : 1;
    ck_req = is_t ? "R5 sck phases" : "R4 sck phases";
    @(negedge clk);
    cpol = pol; cedge = ce; smp_late = sm; clk_sel = sel;
    wdata = txb; wr = 1'b1; tmr_match = 1'b0;
    hp = 0; cnt = 0; k = 0; tc = 0; waiting = is_t; fin = 1'b0;
    e_sck = 0; e_sdo = 0; e_busy = 0; leads = 0; prev_sck = pol;
    while (!fin && k < 4000) begin
      @(negedge clk);
      k++;
      wr       = (k == coll_k);
      wcol_clr = clr_too && (k == coll_k);
      wdata    = (k == coll_k) ? ~txb : txb;
      if (busy !== 1'b1) e_busy++;
      if (sck !== (pol ^ hp[0])) e_sck++;
      if (sck !== pol && prev_sck === pol) leads++;
      prev_sck = sck;
      jo = (hp < off) ? 0 : (hp - off) / 2;
      if (jo > 7) jo = 7;
      if (sdo !== txb[7-jo]) e_sdo++;
      tm = is_t && ((tc % tper) == tphase);
      tc++;
      tmr_match = tm;
      tk = is_t ? tm : (cnt == hh - 1);
      rc = hp - off - int'(sm);
      if (tk && !waiting && rc >= 0 && rc <= 14 && (rc % 2) == 0) sdi = rxp[7 - rc/2];
      else sdi = 1'($urandom);
      if (!is_t) cnt = tk ? 0 : cnt + 1;
      if (tk) begin
        if (waiting) waiting = 1'b0;
        else if (hp == 16) fin = 1'b1;
        else hp++;
      end
    end
    @(negedge clk);
    wr = 1'b0; wcol_clr = 1'b0; tmr_match = 1'b0;
    chk(fin, "R10 transfer ended", fin, 1);
    chk(e_busy == 0, "R1 busy through transfer", e_busy, 0);
    chk(e_sck == 0, ck_req, e_sck, 0);
    chk(leads == 8, "R1 pulse count", leads, 8);
    chk(e_sdo == 0, "R1 R6 sdo msb-first", e_sdo, 0);
    chk(busy == 1'b0, "R10 busy falls", busy, 0);
    chk(sck == pol, "R2 idle level", sck, pol);
    chk(rx_data == rxp, "R3 received byte", rx_data, rxp);
    @(negedge clk);
    chk(rx_valid == 1'b1, "R8 rx_valid rises", rx_valid, 1);
    chk(wcol == (coll_k > 0), "R6 collision flag", wcol, (coll_k > 0));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, "R8 rx_valid taken", rx_valid, 0);
    if (wcol) begin
      wcol_clr = 1'b1;
      @(negedge clk);
      wcol_clr = 1'b0;
      chk(wcol == 1'b0, "R7 wcol cleared", wcol, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(busy == 1'b0 && wcol == 1'b0 && rx_valid == 1'b0, "R9 reset idle", {busy, wcol, rx_valid}, 0);
    chk(sck == 1'b0, "R2 disabled idle low", sck, 0);
    cpol = 1'b1;
    @(negedge clk);
    chk(sck == 1'b1, "R2 disabled idle high", sck, 1);
    // Write while disabled is ignored
    wr = 1'b1; wdata = 8'h3C;
    @(negedge clk);
    wr = 1'b0;
    chk(busy == 1'b0, "R9 write while disabled", busy, 0);
    // Enable in every polarity/edge combination: no pulse
    for (int m = 0; m < 4; m++) begin
      en = 1'b0; cpol = m[0]; cedge = m[1];
      @(negedge clk);
      en = 1'b1;
      bad = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (sck !== cpol || busy !== 1'b0) bad++;
      end
      chk(bad == 0, "R9 enable without pulse", bad, 0);
    end
    // Directed: late sampling with clock-edge bit clear, last bit matters
    run_xfer(1'b0, 1'b0, 1'b1, 4'b0000, 8'hA5, 8'h01, 4, 0, 0, 1'b0);
    run_xfer(1'b1, 1'b0, 1'b1, 4'b0000, 8'h5A, 8'hFE, 4, 0, 0, 1'b0);
    // Directed: timer source with several phases of the running timer
    run_xfer(1'b0, 1'b1, 1'b0, 4'b0011, 8'hC3, 8'h96, 7, 0, 0, 1'b0);
    run_xfer(1'b0, 1'b1, 1'b1, 4'b0011, 8'h81, 8'h7E, 7, 6, 0, 1'b0);
    run_xfer(1'b1, 1'b0, 1'b0, 4'b0011, 8'h0F, 8'hF0, 5, 3, 0, 1'b0);
    // Directed: collision together with a clear, set wins (R7)
    run_xfer(1'b0, 1'b1, 1'b0, 4'b0001, 8'h69, 8'h2D, 4, 0, 5, 1'b1);
    // Directed: reserved select behaves as the slowest division
    run_xfer(1'b1, 1'b1, 1'b1, 4'b1010, 8'hE7, 8'h18, 4, 0, 0, 1'b0);
    // Directed: abort by dropping enable mid-transfer
    @(negedge clk);
    cpol = 1'b0; clk_sel = 4'b0001; wr = 1'b1; wdata = 8'hA5;
    @(negedge clk);
    wr = 1'b0;
    repeat (10) @(negedge clk);
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk(wcol == 1'b1, "R6 collision mid-transfer", wcol, 1);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && wcol == 1'b0 && rx_valid == 1'b0, "R9 disable aborts", {busy, wcol, rx_valid}, 0);
    chk(sck == 1'b0, "R9 abort idle level", sck, 0);
    en = 1'b1;
    run_xfer(1'b0, 1'b0, 1'b0, 4'b0000, 8'h4B, 8'hB4, 4, 0, 0, 1'b0);
    // Constrained random transfers
    for (int n = 0; n < 40; n++) begin
      logic [3:0] s;
      int tp, ck;
      s = 4'($urandom % 5);
      if (s == 4'd4) s = 4'b1100;
      tp = 3 + int'($urandom % 7);
      ck = (($urandom % 3) == 0) ? 1 + int'($urandom % 20) : 0;
      run_xfer(1'($urandom), 1'($urandom), 1'($urandom), s, 8'($urandom), 8'($urandom),
               tp, int'($urandom % tp), ck, 1'b0);
    end
    finish_run();
  end

endmodule